// File: doc/BRIEF.md
# Sixteen-Pin Register-Mapped I/O Expander Core

This core gives a host sixteen general-purpose pins, grouped as two byte-wide ports. Each port has four byte registers: a direction byte, an output-level byte, an inversion byte and a captured-input byte. The host reaches all of them through a byte-wide register interface with a 3-bit index and separate read and write strobes. The interface is meant to sit behind a serial slave engine. The core drives per-pin output enables and levels. It also raises an active-low interrupt when a pin set as an input no longer matches the level captured for it.

Pin levels first pass through a synchroniser chain. A read of a port's input byte captures that port's synchronised pins, and this capture is what rearms its interrupt contribution.

A second, active-low reset input (`ext_rst_n`) behaves in one of two ways, chosen by a parameter. It can return the whole register file to its defaults. Or it can stop only the host side, meaning writes are blocked and read data is cleared, so the pins keep driving their last setup while a stuck bus is recovered.

Top module: `ioexp16_core`

## Requirements
- R1: After `rst_n` is released, every pin is an input (`pin_oe` all 0), `pin_out` is all ones, and the inversion bytes read 0x00. The direction and output bytes read 0xFF, and `int_n` is high while the pins are all high.
- R2: The index selects the byte: 2/3 are output port 0/1, 4/5 are inversion port 0/1, 6/7 are direction port 0/1. Bit 0 of the index picks the port. A write takes effect at the next clock edge. A read strobe loads `reg_rdata` at the next edge, and `reg_rdata` holds that value until the next read.
- R3: Writes to index 0 or 1 change no register.
- R4: `pin_oe` is the bitwise inverse of the direction bytes, where direction 1 means input and 0 means output. `pin_out` carries the output bytes, with port 1 in the upper byte.
- R5: A read of index 0/1 returns that port's synchronised pins XOR its inversion byte. The raw synchronised pins are captured as that port's input byte.
- R6: `int_n` falls two clock edges after an input-direction pin comes to differ from its captured level. Pins set as outputs never assert it.
- R7: A read of one port's input byte removes only that port's contribution to the interrupt.
- R8: `int_n` returns high, with no read, two edges after the pins go back to their captured levels.
- R9: With `KEEP_REGS`=0, while `ext_rst_n` is low, every register is held at its default (captured inputs 0xFF), writes are ignored, and `reg_rdata` is 0.
- R10: With `KEEP_REGS`=1, while `ext_rst_n` is low, the direction, output, inversion and captured-input bytes keep their values. Writes are ignored and `reg_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| ext_rst_n | input | 1 | Synchronous external reset, active low, effect set by `KEEP_REGS` |
| reg_addr | input | 3 | Register index |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | PORT_W | Write data |
| reg_rdata | output | PORT_W | Read data, registered |
| pin_in | input | 2*PORT_W | Asynchronous pin levels |
| pin_out | output | 2*PORT_W | Pin drive levels |
| pin_oe | output | 2*PORT_W | Pin drive enables, 1 drives |
| int_n | output | 1 | Input-change interrupt, active low |

## Verification
A corrupted direction or output byte shows up on `pin_oe` or `pin_out` one edge after it happens. A corrupted captured-input byte shows up on `int_n` straight away, as a spurious low or a missed low. A wrong byte or port selection only shows in `reg_rdata` after the next read of that index, so the bench reads back every index it writes. The interrupt is checked on exact edges, both while the synchroniser fills and after each port's read. This catches a missing or extra stage, and a read that clears the wrong port.

// File: rtl/ioexp16_core.sv
module ioexp16_core #(
  parameter int PORT_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter bit KEEP_REGS   = 1'b0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ext_rst_n,
  input  logic [2:0]            reg_addr,
  input  logic                  reg_wr,
  input  logic                  reg_rd,
  input  logic [PORT_W-1:0]     reg_wdata,
  output logic [PORT_W-1:0]     reg_rdata,
  input  logic [2*PORT_W-1:0]   pin_in,
  output logic [2*PORT_W-1:0]   pin_out,
  output logic [2*PORT_W-1:0]   pin_oe,
  output logic                  int_n
);
  localparam int NPIN = 2*PORT_W;
  localparam logic [PORT_W-1:0] OUT_DEF = '1;
  localparam logic [PORT_W-1:0] POL_DEF = '0;
  localparam logic [PORT_W-1:0] CFG_DEF = '1;
  localparam logic [PORT_W-1:0] IN_DEF  = '1;

  logic [SYNC_STAGES-1:0][NPIN-1:0] sync_q;
  logic [NPIN-1:0]              pin_s;
  logic [1:0][PORT_W-1:0]       port_rd;
  logic [1:0]                   port_diff;
  logic                         file_clr;

  assign pin_s    = sync_q[SYNC_STAGES-1];
  assign file_clr = !KEEP_REGS && !ext_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
    end else begin
      for (int i = SYNC_STAGES-1; i > 0; i--) sync_q[i] <= sync_q[i-1];
      sync_q[0] <= pin_in;
    end
  end

  for (genvar p = 0; p < 2; p++) begin : g_port
    localparam logic [2:0] A_IN  = 3'(p);
    localparam logic [2:0] A_OUT = 3'(2 + p);
    localparam logic [2:0] A_POL = 3'(4 + p);
    localparam logic [2:0] A_CFG = 3'(6 + p);

    logic [PORT_W-1:0] in_q, out_q, pol_q, cfg_q, pin_b;

    assign pin_b = pin_s[p*PORT_W +: PORT_W];
    assign pin_out[p*PORT_W +: PORT_W] = out_q;
    assign pin_oe[p*PORT_W +: PORT_W]  = ~cfg_q;
    assign port_diff[p] = |((pin_b ^ in_q) & cfg_q);
    assign port_rd[p] = (reg_addr[2:1] == 2'd0) ? (pin_b ^ pol_q) :
                        (reg_addr[2:1] == 2'd1) ? out_q :
                        (reg_addr[2:1] == 2'd2) ? pol_q : cfg_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        in_q  <= IN_DEF;
        out_q <= OUT_DEF;
        pol_q <= POL_DEF;
        cfg_q <= CFG_DEF;
      end else if (file_clr) begin
        in_q  <= IN_DEF;
        out_q <= OUT_DEF;
        pol_q <= POL_DEF;
        cfg_q <= CFG_DEF;
      end else if (ext_rst_n) begin
        if (reg_wr && reg_addr == A_OUT) out_q <= reg_wdata;
        if (reg_wr && reg_addr == A_POL) pol_q <= reg_wdata;
        if (reg_wr && reg_addr == A_CFG) cfg_q <= reg_wdata;
        if (reg_rd && reg_addr == A_IN)  in_q  <= pin_b;
      end
    end
  end

  assign int_n = ~|port_diff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         reg_rdata <= '0;
    else if (!ext_rst_n) reg_rdata <= '0;
    else if (reg_rd)    reg_rdata <= port_rd[reg_addr[0]];
  end
endmodule

// File: rtl/ioexp16_chk.sv
module ioexp16_chk #(
  parameter int PORT_W    = 8,
  parameter bit KEEP_REGS = 1'b0
) (
  input logic                clk,
  input logic                rst_n,
  input logic                ext_rst_n,
  input logic [2:0]          reg_addr,
  input logic                reg_wr,
  input logic                reg_rd,
  input logic [PORT_W-1:0]   reg_wdata,
  input logic [PORT_W-1:0]   reg_rdata,
  input logic [2*PORT_W-1:0] pin_out,
  input logic [2*PORT_W-1:0] pin_oe,
  input logic                int_n
);
  p_wr_out_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && ext_rst_n && reg_addr == 3'd2 |=> pin_out[PORT_W-1:0] == $past(reg_wdata));

  p_rd_cfg_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd && ext_rst_n && reg_addr == 3'd6 |=> reg_rdata == ~$past(pin_oe[PORT_W-1:0]));

  p_rdata_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd && ext_rst_n |=> $stable(reg_rdata));

  p_outputs_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pin_oe == '1 |-> int_n);

  p_file_default_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !KEEP_REGS && !ext_rst_n |=> pin_oe == '0 && pin_out == '1 && reg_rdata == '0);

  p_file_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    KEEP_REGS && !ext_rst_n |=> $stable(pin_oe) && $stable(pin_out) && reg_rdata == '0);
endmodule

bind ioexp16_core ioexp16_chk #(.PORT_W(PORT_W), .KEEP_REGS(KEEP_REGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .ext_rst_n(ext_rst_n), .reg_addr(reg_addr),
  .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .pin_out(pin_out), .pin_oe(pin_oe), .int_n(int_n)
);

// File: tb/tb_ioexp16_core.sv
module tb_ioexp16_core;
  localparam time CLK_P = 20ns;

  logic clk = 0, rst_n = 0, ext_rst_n = 1, reg_wr = 0, reg_rd = 0;
  logic [2:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [15:0] pin_in = 16'hFFFF;
  logic [7:0]  rd_a, rd_b;
  logic [15:0] out_a, out_b, oe_a, oe_b;
  logic        int_a, int_b;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  int          kind_q[$];
  logic [15:0] val_q[$];
  string       req_q[$];

  always #(CLK_P/2) clk = ~clk;

  ioexp16_core #(.KEEP_REGS(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .ext_rst_n(ext_rst_n), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(rd_a),
    .pin_in(pin_in), .pin_out(out_a), .pin_oe(oe_a), .int_n(int_a));

  ioexp16_core #(.KEEP_REGS(1'b1)) dut_keep (
    .clk(clk), .rst_n(rst_n), .ext_rst_n(ext_rst_n), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(rd_b),
    .pin_in(pin_in), .pin_out(out_b), .pin_oe(oe_b), .int_n(int_b));

  function automatic logic [15:0] observe(int k);
    case (k)
      0: return {8'h00, rd_a};
      1: return {15'd0, int_a};
      2: return oe_a;
      3: return out_a;
      4: return {8'h00, rd_b};
      5: return oe_b;
      6: return out_b;
      default: return {15'd0, int_b};
    endcase
  endfunction

  // Monitor: each queued item is compared after the next rising edge
  initial forever begin
    @(posedge clk); #5;
    while (kind_q.size() > 0) begin
      int k;
      logic [15:0] v, act;
      string r;
      k = kind_q.pop_front(); v = val_q.pop_front(); r = req_q.pop_front();
      act = observe(k);
      n_cmp++;
      if (act !== v) begin
        n_bad++;
        $display("FAIL %s signal#%0d actual=%h expected=%h at %0t", r, k, act, v, $time);
      end
    end
  end

  task automatic expect_v(int k, logic [15:0] v, string r);
    kind_q.push_back(k); val_q.push_back(v); req_q.push_back(r);
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(logic [2:0] a, logic [7:0] e, string r);
    reg_addr = a; reg_rd = 1; expect_v(0, {8'h00, e}, r);
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic rd2(logic [2:0] a, logic [7:0] e, logic [7:0] ek, string r);
    expect_v(4, {8'h00, ek}, r);
    rd(a, e, r);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1;
    // R1 defaults
    expect_v(2, 16'h0000, "R1"); expect_v(3, 16'hFFFF, "R1"); expect_v(1, 16'h1, "R1");
    tick();
    rd(3'd4, 8'h00, "R1"); rd(3'd6, 8'hFF, "R1"); rd(3'd3, 8'hFF, "R1");
    // R2 map and hold
    wr(3'd2, 8'hA5); rd(3'd2, 8'hA5, "R2");
    wr(3'd5, 8'h3C); rd(3'd5, 8'h3C, "R2");
    wr(3'd7, 8'h0F); rd(3'd7, 8'h0F, "R2");
    tick(); tick();
    expect_v(0, 16'h000F, "R2"); tick();
    // R4 pin drive
    expect_v(2, 16'hF000, "R4"); expect_v(3, 16'hFFA5, "R4"); tick();
    // R3 input bytes are read-only
    wr(3'd0, 8'h00); rd(3'd0, 8'hFF, "R3");
    wr(3'd1, 8'h12); rd(3'd1, 8'hC3, "R3");
    rd(3'd2, 8'hA5, "R3");
    // R5 / R7 capture and per-port clear
    pin_in = 16'h5A96;
    repeat (3) tick();
    expect_v(1, 16'h0, "R7"); rd(3'd0, 8'h96, "R5");
    expect_v(1, 16'h1, "R7"); rd(3'd1, 8'h66, "R5");
    // R6 latency on an input pin
    pin_in = 16'h5A97;
    expect_v(1, 16'h1, "R6"); tick();
    expect_v(1, 16'h0, "R6"); tick();
    // R8 release without a read
    pin_in = 16'h5A96;
    expect_v(1, 16'h0, "R8"); tick();
    expect_v(1, 16'h1, "R8"); tick();
    // R6 output-direction pin ignored
    pin_in = 16'hDA96;
    repeat (3) tick();
    expect_v(1, 16'h1, "R6"); tick();
    // R5 inversion
    wr(3'd4, 8'hFF); rd(3'd0, 8'h69, "R5");
    rd(3'd1, 8'hE6, "R5");
    // R9 / R10 external reset
    ext_rst_n = 0;
    expect_v(2, 16'h0000, "R9"); expect_v(3, 16'hFFFF, "R9"); expect_v(1, 16'h0, "R9");
    expect_v(5, 16'hF000, "R10"); expect_v(6, 16'hFFA5, "R10"); expect_v(7, 16'h1, "R10");
    tick();
    wr(3'd2, 8'h00);
    expect_v(3, 16'hFFFF, "R9"); expect_v(6, 16'hFFA5, "R10");
    rd2(3'd2, 8'h00, 8'h00, "R9 R10");
    ext_rst_n = 1;
    tick();
    rd2(3'd4, 8'h00, 8'hFF, "R9 R10");
    rd2(3'd7, 8'hFF, 8'h0F, "R9 R10");
    rd2(3'd3, 8'hFF, 8'hFF, "R9 R10");
    repeat (3) tick();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule